// File: doc/BRIEF.md
# Memory Region Attribute Decoder

The decoder holds one 64-bit default region configuration word and looks up, for every 32-bit physical address presented to it, the 8-bit property byte that governs accesses to that address. Two programmable page boundaries, each with 4 KB granularity, split the address space into three ordered regions:

- system memory, below the system top;
- device space, from the system top up to the ROM base;
- boot ROM, at and above the ROM base.

A fixed legacy window at 0x000A0000–0x000FFFFF takes its property byte from a separate input. That window overrides the system memory region and no other region.

The configuration word is written and read through a plain single-cycle register port. Lookups are pipelined by one register stage. Each result carries the property byte and a 2-bit region index.

Top module: `region_attr_decoder`

## Requirements
- R1: After reset the configuration word reads 0x01FFFFF0_10000001.
- R2: The configuration word has these fields: ROM properties [63:56], ROM base page [55:36], device properties [35:28], system top page [27:8], system properties [7:0]. A write stores the word and it reads back on the next cycle. The reserved property bits (63:62, 35:34, 7:6) always read as zero.
- R3: A lookup whose address bits 31:12 are at or above the ROM base page returns the ROM properties with region index 2.
- R4: A lookup below the ROM base page and at or above the system top page returns the device properties with region index 1.
- R5: A lookup below the system top page and outside the legacy window returns the system properties with region index 0.
- R6: A lookup in 0x000A0000–0x000FFFFF returns `legacy_props` (sampled with the address) with region index 3, provided it would otherwise fall in system memory. In device or ROM space the window has no effect.
- R7: When the system top page is above the ROM base page, the ROM comparison wins and no address decodes as device space.
- R8: `res_valid` rises exactly one cycle after `lk_valid`. When `res_valid` is low, `res_props` and `res_region` are zero.
- R9: A lookup presented in the same cycle as a write uses the old configuration. A lookup presented on the following cycle uses the new one.
- R10: Bits 7:6 of `res_props` are always zero, including when `legacy_props` has them set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 64 | Configuration write data |
| cfg_rdata | output | 64 | Current configuration word |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Physical address to classify |
| legacy_props | input | 8 | Property byte of the fixed legacy window |
| res_valid | output | 1 | Lookup result valid |
| res_props | output | 8 | Property byte of the looked-up address |
| res_region | output | 2 | Region index: 0 system, 1 device, 2 ROM, 3 legacy window |

## Verification
The bench probes both sides of every boundary:

- The ROM base and system top pages. A design with an off-by-one compare (for example `>` instead of `>=`) would put the first page of a region into its neighbour.
- Both ends of the legacy window, and the window placed above the system top. A decoder that let the window override device space would report region 3 where region 1 is expected.
- An inverted ROM/system pair. Here a wrong priority would leak device properties.
- A write issued together with a lookup. A design that bypassed the new word into the same-cycle lookup would return the wrong properties.
- Reserved property bits set in both the written word and the legacy input. A design without masking would leak them.

// File: rtl/region_attr_pkg.sv
package region_attr_pkg;

    localparam int ADDR_W    = 32;
    localparam int PAGE_SH   = 12;
    localparam int PAGE_W    = ADDR_W - PAGE_SH;
    localparam int PROP_W    = 8;
    localparam int CFG_W     = 3 * PROP_W + 2 * PAGE_W;

    localparam logic [PROP_W-1:0] PROP_MASK = 8'h3F;

    localparam logic [CFG_W-1:0] CFG_MASK =
        {PROP_MASK, {PAGE_W{1'b1}}, PROP_MASK, {PAGE_W{1'b1}}, PROP_MASK};

    localparam logic [CFG_W-1:0] CFG_RESET = 64'h01FF_FFF0_1000_0001;

    typedef enum logic [1:0] {
        REG_SYS    = 2'd0,
        REG_DEV    = 2'd1,
        REG_ROM    = 2'd2,
        REG_LEGACY = 2'd3
    } region_t;

    typedef struct packed {
        logic [PROP_W-1:0] rom_props;
        logic [PAGE_W-1:0] rom_base;
        logic [PROP_W-1:0] dev_props;
        logic [PAGE_W-1:0] sys_top;
        logic [PROP_W-1:0] sys_props;
    } cfg_t;

endpackage

// File: rtl/region_cfg_reg.sv
module region_cfg_reg
    import region_attr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output cfg_t             cfg_q
);

    cfg_t cfg_d;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            cfg_d = cfg_t'(wdata & CFG_MASK);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= cfg_t'(CFG_RESET);
        end else begin
            cfg_q <= cfg_d;
        end
    end

    // R2: a written word shows up masked on the next cycle
    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (cfg_q == cfg_t'($past(wdata) & CFG_MASK)));

endmodule

// File: rtl/region_classify.sv
module region_classify
    import region_attr_pkg::*;
#(
    parameter logic [PAGE_W-1:0] LEG_LO_PAGE = 20'h000A0,
    parameter logic [PAGE_W-1:0] LEG_HI_PAGE = 20'h000FF
) (
    input  cfg_t              cfg,
    input  logic [PAGE_W-1:0] page,
    input  logic [PROP_W-1:0] legacy_props,
    output region_t           region,
    output logic [PROP_W-1:0] props
);

    logic in_rom, in_dev, in_leg;

    always_comb begin
        in_rom = (page >= cfg.rom_base);
        in_dev = (page >= cfg.sys_top);
        in_leg = (page >= LEG_LO_PAGE) && (page <= LEG_HI_PAGE);

        if (in_rom) begin
            region = REG_ROM;
            props  = cfg.rom_props;
        end else if (in_dev) begin
            region = REG_DEV;
            props  = cfg.dev_props;
        end else if (in_leg) begin
            region = REG_LEGACY;
            props  = legacy_props;
        end else begin
            region = REG_SYS;
            props  = cfg.sys_props;
        end
        props = props & PROP_MASK;
    end

endmodule

// File: rtl/region_attr_decoder.sv
module region_attr_decoder
    import region_attr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [63:0] cfg_wdata,
    output logic [63:0] cfg_rdata,
    input  logic        lk_valid,
    input  logic [31:0] lk_addr,
    input  logic [7:0]  legacy_props,
    output logic        res_valid,
    output logic [7:0]  res_props,
    output logic [1:0]  res_region
);

    localparam logic [PAGE_W-1:0] LEG_LO = 20'h000A0;
    localparam logic [PAGE_W-1:0] LEG_HI = 20'h000FF;

    typedef struct packed {
        logic              valid;
        region_t           region;
        logic [PROP_W-1:0] props;
    } res_t;

    cfg_t              cfg_q;
    region_t           cls_region;
    logic [PROP_W-1:0] cls_props;
    logic [PAGE_W-1:0] page;
    res_t              res_d, res_q;

    assign page = lk_addr[ADDR_W-1:PAGE_SH];

    region_cfg_reg i_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg_q (cfg_q)
    );

    region_classify #(
        .LEG_LO_PAGE (LEG_LO),
        .LEG_HI_PAGE (LEG_HI)
    ) i_cls (
        .cfg          (cfg_q),
        .page         (page),
        .legacy_props (legacy_props),
        .region       (cls_region),
        .props        (cls_props)
    );

    always_comb begin
        res_d = '0;
        if (lk_valid) begin
            res_d.valid  = 1'b1;
            res_d.region = cls_region;
            res_d.props  = cls_props;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign cfg_rdata  = cfg_q;
    assign res_valid  = res_q.valid;
    assign res_props  = res_q.props;
    assign res_region = res_q.region;

    // R8: a lookup produces a result one cycle later
    assert_result_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_valid);

    // R8: idle outputs are zero
    assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (res_props == 8'h00 && res_region == 2'd0));

    // R10: reserved property bits never leave the block
    assert_rsvd_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        res_props[7:6] == 2'b00);

    // R3: pages at or above the ROM base decode as ROM
    assert_rom_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && page >= cfg_q.rom_base) |=>
            (res_region == 2'd2 && res_props == $past(cfg_q.rom_props)));

    // R6: the legacy window under the system top takes the legacy byte
    assert_legacy_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && page >= LEG_LO && page <= LEG_HI &&
         page < cfg_q.sys_top && page < cfg_q.rom_base) |=>
            (res_region == 2'd3 && res_props == ($past(legacy_props) & 8'h3F)));

endmodule

// File: tb/test_region_attr_decoder.sv
module test_region_attr_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [63:0] cfg_wdata = '0;
    logic [63:0] cfg_rdata;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_addr = '0;
    logic [7:0]  legacy_props = '0;
    logic        res_valid;
    logic [7:0]  res_props;
    logic [1:0]  res_region;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [63:0] model = 64'h01FF_FFF0_1000_0001;
    logic [7:0]  q_props[$];
    logic [1:0]  q_region[$];
    string       q_tag[$];

    always #2 clk = ~clk;

    region_attr_decoder i_region_attr_decoder (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .lk_valid(lk_valid), .lk_addr(lk_addr),
        .legacy_props(legacy_props), .res_valid(res_valid),
        .res_props(res_props), .res_region(res_region)
    );

    function automatic logic [9:0] expect_of(logic [63:0] c, logic [31:0] a,
                                             logic [7:0] leg);
        logic [19:0] pg;
        pg = a[31:12];
        if (pg >= c[55:36])
            return {2'd2, c[63:56] & 8'h3F};
        if (pg >= c[27:8])
            return {2'd1, c[35:28] & 8'h3F};
        if (a >= 32'h000A_0000 && a <= 32'h000F_FFFF)
            return {2'd3, leg & 8'h3F};
        return {2'd0, c[7:0] & 8'h3F};
    endfunction

    task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic push_lookup(logic [31:0] a, logic [7:0] leg, string tag);
        logic [9:0] e;
        lk_valid     = 1'b1;
        lk_addr      = a;
        legacy_props = leg;
        e = expect_of(model, a, leg);
        q_region.push_back(e[9:8]);
        q_props.push_back(e[7:0]);
        q_tag.push_back(tag);
    endtask

    task automatic lookup(logic [31:0] a, logic [7:0] leg, string tag);
        @(negedge clk);
        cfg_we = 1'b0;
        push_lookup(a, leg, tag);
    endtask

    task automatic idle();
        @(negedge clk);
        cfg_we   = 1'b0;
        lk_valid = 1'b0;
    endtask

    // write, optionally with a lookup in the same cycle (uses the old word)
    task automatic write_cfg(logic [63:0] w, bit with_lk, logic [31:0] a, string tag);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = w;
        if (with_lk) push_lookup(a, 8'h00, tag);
        else lk_valid = 1'b0;
        model = w & 64'h3FFF_FFF3_FFFF_FF3F;
    endtask

    // monitor: compare each result against the scoreboard queue
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n) begin
                if (res_valid) begin
                    if (q_tag.size() == 0) begin
                        check(1'b0, "R8 unexpected result", 64'(res_valid), 64'd0);
                    end else begin
                        logic [7:0] ep;
                        logic [1:0] er;
                        string t;
                        ep = q_props.pop_front();
                        er = q_region.pop_front();
                        t  = q_tag.pop_front();
                        check(res_props == ep, {t, " props"}, 64'(res_props), 64'(ep));
                        check(res_region == er, {t, " region"}, 64'(res_region), 64'(er));
                    end
                end else begin
                    check(q_tag.size() == 0, "R8 missing result", 64'(q_tag.size()), 64'd0);
                    check(res_props == 8'h00 && res_region == 2'd0, "R8 idle outputs",
                          {54'd0, res_region, res_props}, 64'd0);
                end
            end
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(cfg_rdata == 64'h01FF_FFF0_1000_0001, "R1 reset word",
              cfg_rdata, 64'h01FF_FFF0_1000_0001);
        check(res_valid == 1'b0, "R8 reset valid", 64'(res_valid), 64'd0);
        rst_n = 1'b1;

        // default word: sys top page 0, rom base 0xFFFFF
        lookup(32'h0000_0000, 8'h00, "R4 default low");
        lookup(32'hFFFF_EFFF, 8'h00, "R4 default below rom");
        lookup(32'hFFFF_F000, 8'h00, "R3 default rom page");
        idle();

        // program: rom 0xFFF00, sys top 0x08000, reserved bits set
        write_cfg({8'hC5, 20'hFFF00, 8'hE1, 20'h08000, 8'hD2}, 1'b0, 32'h0, "");
        idle();
        check(cfg_rdata == {8'h05, 20'hFFF00, 8'h21, 20'h08000, 8'h12}, "R2 readback",
              cfg_rdata, {8'h05, 20'hFFF00, 8'h21, 20'h08000, 8'h12});

        lookup(32'h0000_0000, 8'h3C, "R5 zero");
        lookup(32'h0009_FFFF, 8'h3C, "R5 below window");
        lookup(32'h000A_0000, 8'hFF, "R6 window low R10");
        lookup(32'h000F_FFFF, 8'h2A, "R6 window high");
        lookup(32'h0010_0000, 8'h2A, "R5 above window");
        lookup(32'h07FF_FFFF, 8'h00, "R5 below top");
        lookup(32'h0800_0000, 8'h00, "R4 at top");
        lookup(32'hFFEF_FFFF, 8'h00, "R4 below rom");
        lookup(32'hFFF0_0000, 8'h00, "R3 at rom");
        lookup(32'hFFFF_FFFF, 8'h00, "R3 top of space");
        idle();

        // write together with lookups: old word then new word
        write_cfg({8'h04, 20'h80000, 8'h08, 20'hFFFFF, 8'h02}, 1'b1, 32'h9000_0000,
                  "R9 same-cycle old word");
        lookup(32'h9000_0000, 8'h00, "R9 next-cycle new word R7");
        lookup(32'h7FFF_FFFF, 8'h00, "R7 below rom is system");
        lookup(32'h8000_0000, 8'h00, "R7 rom boundary");
        lookup(32'h000C_0000, 8'h11, "R6 window inverted cfg");
        idle();

        // legacy window above the system top: no effect
        write_cfg({8'h04, 20'hFFFFF, 8'h08, 20'h00050, 8'h02}, 1'b0, 32'h0, "");
        lookup(32'h000A_0000, 8'h33, "R6 window in device space");
        lookup(32'h0004_FFFF, 8'h33, "R5 below low top");
        idle();
        idle();
        idle();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule